// File: doc/BRIEF.md
# Column-Streaming Four-Neighbour Averaging Pipeline

This block applies a four-neighbour averaging stencil to a two-dimensional fixed-point array. The array has `ROWS` rows and any number of columns. It arrives as a stream of samples, one column after another. Inside each column the samples come in ascending row order, starting at row 0. The first sample of an array is marked by a start flag. That flag also discards any window state left over from an earlier array.

Three column banks are kept in a rotating ring. The column currently arriving is written into a free bank. The two banks before it hold the left column and the middle column. The new sample is the right neighbour.

The result is computed in three stages:
- Stage one forms the left plus right sum and reads the upper and lower neighbours from the stored middle column.
- Stage two adds the upper and lower neighbours.
- Stage three divides by four with an arithmetic shift.

From the third column of an array onward, every accepted input sample yields exactly one result sample. That result belongs to the middle column, at the same row. Both stream edges use a valid/ready handshake. A stalled output freezes the whole pipeline and withholds input ready.

Top module: `stencil_col_pipe`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Samples are taken in column-major order: rows 0 to ROWS-1 of one column, then the next column. A sample accepted with `in_sop`=1 is row 0 of column 0 of a new array.
- R3: Samples of columns 0 and 1 of an array produce no output. Each accepted sample of column c≥2, row r produces exactly one output: the result for column c-1, row r. Outputs come in acceptance order.
- R4: For rows 1 to ROWS-2 the output is floor((L+R+U+D)/4). Here L and R are the samples at the same row in columns c-2 and c. U and D are the samples at rows r-1 and r+1 of column c-1. All values are 32-bit two's complement. The sum is formed without overflow, even at full-scale values.
- R5: For row 0 and row ROWS-1 the output equals the column c-1 sample at that row, unchanged.
- R6: With `out_ready` held at 1, the result appears on `out_data` with `out_valid`=1 after the third rising edge, counting the edge that accepts the input sample.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0. At the next edge `out_valid` stays 1 and `out_data` keeps its value.
- R8: A start flag accepted in the middle of an array discards the old window. The next two columns then produce no output, and later results use only the new array's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can take an input sample this cycle |
| in_sop | input | 1 | Marks row 0 of column 0 of a new array |
| in_data | input | DATA_W | Input sample, two's complement |
| out_valid | output | 1 | Result sample is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | DATA_W | Result sample, two's complement |

## Verification
A wrong row counter or bank pointer shows up at the ports on the first result of the third column. Such a fault either pairs a neighbour from the wrong column or row, or shifts an edge-row pass-through onto an interior row. The result is a miscompare within three cycles of the offending sample. A missing guard bit shows up only on full-scale operands, so directed columns at the positive and negative limits are run next to random data. A broken stall path shows up either as output data changing while it is held or as extra outputs, which the per-column output count exposes.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int NUM_BANKS = 3;

  typedef logic [1:0] bank_sel_t;

  function automatic bank_sel_t bank_prev(bank_sel_t b);
    return (b == 2'd0) ? 2'd2 : b - 2'd1;
  endfunction

  function automatic bank_sel_t bank_next(bank_sel_t b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction
endpackage

// File: rtl/stencil_window.sv
module stencil_window
  import stencil_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ROWS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_fire,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  output logic              s1_valid,
  output logic [DATA_W:0]   s1_hsum,
  output logic [DATA_W-1:0] s1_mid,
  output logic [DATA_W-1:0] s1_up,
  output logic [DATA_W-1:0] s1_down,
  output logic              s1_edge
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q, cur_row, up_row, dn_row;
  bank_sel_t        wr_bank_q, cur_bank, mid_bank, left_bank;
  logic [1:0]       cols_q, cur_cols;
  logic             last_row;

  logic [DATA_W-1:0] rd_at [NUM_BANKS];
  logic [DATA_W-1:0] rd_up [NUM_BANKS];
  logic [DATA_W-1:0] rd_dn [NUM_BANKS];
  logic [DATA_W-1:0] left_val;

  // A start flag re-bases the position to column 0, row 0, bank 0.
  always_comb begin
    cur_row   = in_sop ? '0 : row_q;
    cur_bank  = in_sop ? 2'd0 : wr_bank_q;
    cur_cols  = in_sop ? 2'd0 : cols_q;
    last_row  = (cur_row == LAST_ROW);
    mid_bank  = bank_prev(cur_bank);
    left_bank = bank_prev(mid_bank);
    up_row    = (cur_row == '0) ? cur_row : cur_row - 1'b1;
    dn_row    = last_row ? cur_row : cur_row + 1'b1;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] col_mem [ROWS];
    always_ff @(posedge clk) begin
      if (in_fire && cur_bank == 2'(g)) col_mem[cur_row] <= in_data;
    end
    assign rd_at[g] = col_mem[cur_row];
    assign rd_up[g] = col_mem[up_row];
    assign rd_dn[g] = col_mem[dn_row];
  end

  assign left_val = rd_at[left_bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q     <= '0;
      wr_bank_q <= 2'd0;
      cols_q    <= 2'd0;
    end else if (in_fire) begin
      if (last_row) begin
        row_q     <= '0;
        wr_bank_q <= bank_next(cur_bank);
        cols_q    <= (cur_cols == 2'd2) ? 2'd2 : cur_cols + 2'd1;
      end else begin
        row_q     <= cur_row + 1'b1;
        wr_bank_q <= cur_bank;
        cols_q    <= cur_cols;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (en) begin
      s1_valid <= in_fire && (cur_cols == 2'd2);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_hsum <= {left_val[DATA_W-1], left_val} + {in_data[DATA_W-1], in_data};
      s1_mid  <= rd_at[mid_bank];
      s1_up   <= rd_up[mid_bank];
      s1_down <= rd_dn[mid_bank];
      s1_edge <= (cur_row == '0) || last_row;
    end
  end

  // R2: the row position never leaves the column.
  p_row_bound_r2: assert property (@(posedge clk) disable iff (rst)
    row_q <= LAST_ROW);
  // R2: the bank pointer stays inside the ring.
  p_bank_range_r2: assert property (@(posedge clk) disable iff (rst)
    wr_bank_q != 2'd3);
  // R8: a start flag never produces a result from the old window.
  p_sop_flush_r8: assert property (@(posedge clk) disable iff (rst)
    in_fire && in_sop |=> !s1_valid);
endmodule

// File: rtl/stencil_vsum.sv
module stencil_vsum #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              s1_valid,
  input  logic [DATA_W:0]   s1_hsum,
  input  logic [DATA_W-1:0] s1_mid,
  input  logic [DATA_W-1:0] s1_up,
  input  logic [DATA_W-1:0] s1_down,
  input  logic              s1_edge,
  output logic              s2_valid,
  output logic [DATA_W+1:0] s2_sum,
  output logic [DATA_W-1:0] s2_mid,
  output logic              s2_edge
);
  localparam int SUM_W = DATA_W + 2;

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else if (en) s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s2_sum  <= {s1_hsum[DATA_W], s1_hsum}
               + {{2{s1_up[DATA_W-1]}}, s1_up}
               + {{2{s1_down[DATA_W-1]}}, s1_down};
      s2_mid  <= s1_mid;
      s2_edge <= s1_edge;
    end
  end

  // R4: non-negative operands never wrap into a negative total.
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    $past(en && s1_valid && !s1_hsum[DATA_W] && !s1_up[DATA_W-1] && !s1_down[DATA_W-1])
    |-> !s2_sum[SUM_W-1]);
  // R4: negative operands never wrap into a non-negative total.
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    $past(en && s1_valid && s1_hsum[DATA_W] && s1_up[DATA_W-1] && s1_down[DATA_W-1])
    |-> s2_sum[SUM_W-1]);
endmodule

// File: rtl/stencil_scale.sv
module stencil_scale #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              s2_valid,
  input  logic [DATA_W+1:0] s2_sum,
  input  logic [DATA_W-1:0] s2_mid,
  input  logic              s2_edge,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int SUM_W = DATA_W + 2;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (en) out_valid <= s2_valid;
  end

  // Dropping the two low bits is an arithmetic shift by two (floor of /4).
  always_ff @(posedge clk) begin
    if (rst) out_data <= '0;
    else if (en) out_data <= s2_edge ? s2_mid : s2_sum[SUM_W-1:2];
  end

  // R7: a held result stays put.
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !en |=> out_valid && $stable(out_data));
  // R6: a result only appears behind a valid second stage.
  p_origin_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(s2_valid));
endmodule

// File: rtl/stencil_col_pipe.sv
module stencil_col_pipe #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              en, in_fire;
  logic              s1_valid, s1_edge, s2_valid, s2_edge;
  logic [DATA_W:0]   s1_hsum;
  logic [DATA_W-1:0] s1_mid, s1_up, s1_down, s2_mid;
  logic [DATA_W+1:0] s2_sum;

  // One enable moves every stage; it drops only while a result is refused.
  assign en       = !out_valid || out_ready;
  assign in_ready = en;
  assign in_fire  = in_valid && en;

  stencil_window #(.DATA_W(DATA_W), .ROWS(ROWS)) u_window (
    .clk(clk), .rst(rst), .en(en), .in_fire(in_fire), .in_sop(in_sop),
    .in_data(in_data), .s1_valid(s1_valid), .s1_hsum(s1_hsum),
    .s1_mid(s1_mid), .s1_up(s1_up), .s1_down(s1_down), .s1_edge(s1_edge)
  );

  stencil_vsum #(.DATA_W(DATA_W)) u_vsum (
    .clk(clk), .rst(rst), .en(en), .s1_valid(s1_valid), .s1_hsum(s1_hsum),
    .s1_mid(s1_mid), .s1_up(s1_up), .s1_down(s1_down), .s1_edge(s1_edge),
    .s2_valid(s2_valid), .s2_sum(s2_sum), .s2_mid(s2_mid), .s2_edge(s2_edge)
  );

  stencil_scale #(.DATA_W(DATA_W)) u_scale (
    .clk(clk), .rst(rst), .en(en), .s2_valid(s2_valid), .s2_sum(s2_sum),
    .s2_mid(s2_mid), .s2_edge(s2_edge), .out_valid(out_valid), .out_data(out_data)
  );

  // R7: a refused result blocks new input.
  p_stall_blocks_input_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  // R1: the first cycle after reset shows an empty pipeline.
  p_reset_empty_r1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/tb_stencil_col_pipe.sv
`timescale 1ns/1ps
module tb_stencil_col_pipe;
  localparam int DATA_W = 32;
  localparam int ROWS   = 8;
  localparam int MAXC   = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0, in_sop = 1'b0, out_ready = 1'b1;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_ready, out_valid;
  logic [DATA_W-1:0] out_data;

  stencil_col_pipe #(.DATA_W(DATA_W), .ROWS(ROWS)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int out_cnt = 0, cyc = 0;
  int rdy_mode = 0, gap_pct = 0;
  int b_col = 0, b_row = 0;
  bit lat_mode = 1'b1, stall_prev = 1'b0, done = 1'b0;
  logic [DATA_W-1:0] held;
  longint img [MAXC][ROWS];
  logic [DATA_W-1:0] q_exp [$];
  int q_cyc [$];
  bit q_edge [$];

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] gen(int kind, int c, int r);
    case (kind)
      1: return DATA_W'(int'($urandom_range(16)) - 8);
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return (c % 2 == 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
      5: return DATA_W'(c * 100 + r);
      default: return $urandom;
    endcase
  endfunction

  // Monitor: model of the requirements, sampled at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (stall_prev) begin
        check(out_valid === 1'b1, "R7 valid held", out_valid, 1);
        check(out_data === held, "R7 data held", out_data, held);
      end
      stall_prev = out_valid && !out_ready;
      held = out_data;
      if (stall_prev) check(in_ready === 1'b0, "R7 input blocked", in_ready, 0);

      if (out_valid && out_ready) begin
        out_cnt++;
        if (q_exp.size() == 0) begin
          check(1'b0, "R3 unexpected output", out_data, 0);
        end else begin
          automatic logic [DATA_W-1:0] e = q_exp.pop_front();
          automatic int  ac = q_cyc.pop_front();
          automatic bit  ed = q_edge.pop_front();
          check(out_data === e, ed ? "R5 edge row" : "R4 average",
                longint'(signed'(out_data)), longint'(signed'(e)));
          if (lat_mode) check(cyc == ac + 3, "R6 latency", cyc - ac, 3);
        end
      end

      if (in_valid && in_ready) begin
        automatic longint v = longint'(signed'(in_data));
        if (in_sop) begin b_col = 0; b_row = 0; end   // R2 / R8 restart
        img[b_col][b_row] = v;
        if (b_col >= 2) begin
          automatic longint s;
          automatic bit ed = (b_row == 0) || (b_row == ROWS - 1);
          if (ed) s = img[b_col-1][b_row];
          else    s = (img[b_col-2][b_row] + v + img[b_col-1][b_row-1]
                       + img[b_col-1][b_row+1]) >>> 2;
          q_exp.push_back(DATA_W'(s));
          q_cyc.push_back(cyc);
          q_edge.push_back(ed);
        end
        b_row++;
        if (b_row == ROWS) begin b_row = 0; b_col++; end
      end
    end
  end

  // Consumer readiness.
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = (rdy_mode == 0) ? 1'b1 : ($urandom_range(99) < 60);
    end
  end

  task automatic send(logic [DATA_W-1:0] d, bit sop);
    while (gap_pct > 0 && $urandom_range(99) < gap_pct) begin
      @(posedge clk); #1;
    end
    in_valid = 1'b1; in_data = d; in_sop = sop;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic send_array(int ncols, int nlast, int kind);
    for (int c = 0; c < ncols; c++) begin
      automatic int nr = (c == ncols - 1) ? nlast : ROWS;
      for (int r = 0; r < nr; r++) send(gen(kind, c, r), (c == 0 && r == 0));
    end
  endtask

  task automatic drain();
    while (q_exp.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R2, R3, R5, R6: ordered ramp, five columns, no stalls.
    rdy_mode = 0; lat_mode = 1; gap_pct = 0;
    out_cnt = 0;
    send_array(5, ROWS, 5);
    drain();
    check(out_cnt == 3 * ROWS, "R3 output count", out_cnt, 3 * ROWS);

    // R4: full-scale and small signed values (floor toward -inf).
    send_array(4, ROWS, 2); drain();
    send_array(4, ROWS, 3); drain();
    send_array(5, ROWS, 4); drain();
    gap_pct = 30;
    send_array(6, ROWS, 1); drain();

    // R8: restart in the middle of a column.
    gap_pct = 0; out_cnt = 0;
    send_array(4, 4, 0);
    send_array(4, ROWS, 0);
    drain();
    check(out_cnt == 3 * ROWS + 4, "R8 output count after restart", out_cnt, 3 * ROWS + 4);

    // R7 with random backpressure and input gaps.
    rdy_mode = 1; lat_mode = 0; gap_pct = 25;
    for (int a = 0; a < 8; a++) send_array(3 + int'($urandom_range(8)), ROWS, a % 2);
    send_array(6, ROWS, 2);
    send_array(6, ROWS, 4);
    rdy_mode = 0;
    drain();
    check(q_exp.size() == 0, "R3 all results delivered", q_exp.size(), 0);

    done = 1'b1;
    summary();
  end
endmodule